// File: doc/BRIEF.md
# Receive Frame Store with Arrival Ranking

This block keeps up to three received frames, each at most 16 bytes long, in three separate buffers. A bit-level receiver in front of it delivers each frame as a byte stream. A start strobe opens a frame, a byte-valid strobe carries each byte, and an end strobe closes the frame. The block uses the low nibble of the first byte to decide whether to keep the frame. Three programmable logical addresses and the broadcast address are accepted. An accepted frame goes into the lowest-numbered free buffer.

Each occupied buffer carries a 2-bit age rank. Software reads the packed ranks and drains the buffers oldest first through a byte-wide register port. It then frees each buffer with a release bit. When a buffer is freed, the remaining ranks close up, so the oldest frame left always carries rank 1. Each buffer has its own ready interrupt. A sticky flag records frames that were lost because every buffer was full.

Top module: `rx_frame_store`

## Requirements
- R1: After reset, the rank register (address 0x00) reads 0 and the interrupt register (0x02) reads 0. The control register (0x01) reads 0x08, `irq_ready_o` is 0 and `overflow_o` is 0.
- R2: An accepted frame is written to the lowest-indexed free buffer n. Address 0x08+n returns its byte count in bits [4:0]. Byte i of the frame reads at address 0x10 + 16*n + i.
- R3: Address 0x00 holds a 2-bit code for buffer n in bits [2n+1:2n]. Code 0 means empty, and codes 1, 2 and 3 mean oldest, second oldest and third oldest. A newly stored frame gets a code one above the number of occupied buffers, and the codes in use stay distinct and contiguous from 1.
- R4: While bit n of the control register (0x01) is 1, buffer n is emptied and is not used for new frames. Writing the bit back to 0 makes the buffer usable again. Every occupied buffer ranked above a freed buffer moves down by one.
- R5: Bytes past the 16th byte of a frame are discarded. The stored count is then 16.
- R6: The destination is the low nibble of the first byte. It must equal an enabled logical address or 0xF. Slot 0 is the low nibble of 0x03, slot 1 is the high nibble of 0x03 and slot 2 is the low nibble of 0x04. The enables for slots 0, 1 and 2 are bits 4, 5 and 6 of 0x05. Any other frame is dropped.
- R7: A frame that starts while no buffer is available is discarded, and the stored frames and ranks stay unchanged. Bit 3 of 0x02 and `overflow_o` are then set. The flag stays set until a 1 is written to bit 3 of 0x02.
- R8: Bit n of 0x02 and `irq_ready_o[n]` become 1 in the cycle after the end strobe that stores a frame in buffer n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: When bit 3 of the control register is 0, only buffer 0 receives frames. Writing 0x0F empties all buffers.
- R10: A frame that ends with no bytes is not stored. It sets no interrupt and changes no rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_start_i | input | 1 | Opens a new frame; byte and end strobes in the same cycle are ignored |
| frm_byte_vld_i | input | 1 | frm_byte_i carries a frame byte |
| frm_byte_i | input | 8 | Frame byte |
| frm_end_i | input | 1 | Closes the current frame |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data at reg_addr_i |
| irq_ready_o | output | 3 | Per-buffer ready flags |
| overflow_o | output | 1 | Sticky frame-lost flag |

## Verification
The assertions assume that the receiver never raises a byte or end strobe in the same cycle as a start strobe. They also assume that a commit always targets a buffer that was empty when the frame began. This holds because only one frame is open at a time. The stimulus drives every strobe on the falling edge. Each frame is sent as a clean start, then bytes, then end sequence, with a gap of at least one cycle after the end. Register writes never coincide with a frame end, so clear-versus-set collisions do not arise in the directed runs.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;
  localparam int NUM_BUF   = 3;
  localparam int RANK_W    = 2;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 6;
  localparam logic [NIB_W-1:0] BCAST_ADDR = 4'hF;

  localparam logic [ADDR_W-1:0] A_ORDER = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h01;
  localparam logic [ADDR_W-1:0] A_IRQ   = 6'h02;
  localparam logic [ADDR_W-1:0] A_LA01  = 6'h03;
  localparam logic [ADDR_W-1:0] A_LA2   = 6'h04;
  localparam logic [ADDR_W-1:0] A_LAEN  = 6'h05;
  localparam logic [ADDR_W-1:0] A_LEN0  = 6'h08;

  typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_frame_pkg::*;
(
  input  logic [NIB_W-1:0]         dst_i,
  input  logic [NUM_BUF*NIB_W-1:0] la_i,
  input  logic [NUM_BUF-1:0]       en_i,
  output logic                     match_o
);
  always_comb begin
    match_o = (dst_i == BCAST_ADDR);
    for (int k = 0; k < NUM_BUF; k++)
      if (en_i[k] && la_i[k*NIB_W +: NIB_W] == dst_i) match_o = 1'b1;
  end
endmodule

// File: rtl/rx_rank_tracker.sv
module rx_rank_tracker
  import rx_frame_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BUF-1:0]        rel_i,
  input  logic                      commit_i,
  input  logic [1:0]                commit_idx_i,
  output logic [NUM_BUF*RANK_W-1:0] rank_o,
  output logic [NUM_BUF-1:0]        occ_o
);
  rank_t rank_q [NUM_BUF];
  rank_t rank_d [NUM_BUF];
  logic [NUM_BUF-1:0] gone, keep;
  rank_t live;

  always_comb begin
    for (int b = 0; b < NUM_BUF; b++) occ_o[b] = (rank_q[b] != '0);
    gone = occ_o & rel_i;
    keep = occ_o & ~rel_i;
    live = '0;
    for (int b = 0; b < NUM_BUF; b++) live = live + rank_t'(keep[b]);
    for (int b = 0; b < NUM_BUF; b++) begin
      rank_t dec;
      dec = '0;
      for (int j = 0; j < NUM_BUF; j++)
        if (gone[j] && rank_q[j] < rank_q[b]) dec = dec + 1'b1;
      rank_d[b] = keep[b] ? rank_q[b] - dec : '0;
    end
    if (commit_i) rank_d[commit_idx_i] = live + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BUF; b++) rank_q[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BUF; b++) rank_q[b] <= rank_d[b];
    end
  end

  generate
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_pack
      assign rank_o[b*RANK_W +: RANK_W] = rank_q[b];
    end
  endgenerate

  assert_rank_distinct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(occ_o[0] && occ_o[1] && rank_q[0] == rank_q[1]) &&
    !(occ_o[0] && occ_o[2] && rank_q[0] == rank_q[2]) &&
    !(occ_o[1] && occ_o[2] && rank_q[1] == rank_q[2]));

  assert_rank_dense_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rank_q[0]) <= $countones(occ_o)) && (int'(rank_q[1]) <= $countones(occ_o)) &&
    (int'(rank_q[2]) <= $countones(occ_o)));

  assert_commit_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !occ_o[commit_idx_i]);

  assert_release_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(rel_i & occ_o)) && !commit_i) |=> ($countones(occ_o) == $past($countones(occ_o & ~rel_i))));
endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store
  import rx_frame_pkg::*;
#(
  parameter int MAX_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_start_i,
  input  logic              frm_byte_vld_i,
  input  logic [7:0]        frm_byte_i,
  input  logic              frm_end_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [2:0]        irq_ready_o,
  output logic              overflow_o
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(MAX_LEN);

  logic [3:0]         ctrl_q;
  logic [7:0]         la01_q;
  logic [3:0]         la2_q;
  logic [2:0]         laen_q;
  logic [2:0]         irq_q;
  logic               ovf_q;
  logic [7:0]         mem_q [NUM_BUF][MAX_LEN];
  logic [LEN_W-1:0]   len_q [NUM_BUF];
  logic               active_q, drop_q;
  logic [1:0]         tgt_q;
  logic [LEN_W-1:0]   cnt_q;

  logic [NUM_BUF*RANK_W-1:0] rank_pk;
  logic [NUM_BUF-1:0] occ, avail;
  logic [1:0]         pick;
  logic               match, byte_live, byte_take, byte_reject, commit, none_free;
  logic [LEN_W-1:0]   cnt_eff;
  logic [2:0]         irq_set;

  rx_addr_filter u_filter (
    .dst_i  (frm_byte_i[NIB_W-1:0]),
    .la_i   ({la2_q, la01_q}),
    .en_i   (laen_q),
    .match_o(match)
  );

  rx_rank_tracker u_rank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rel_i       (ctrl_q[2:0]),
    .commit_i    (commit),
    .commit_idx_i(tgt_q),
    .rank_o      (rank_pk),
    .occ_o       (occ)
  );

  always_comb begin
    avail = ~occ & ~ctrl_q[2:0] & (ctrl_q[3] ? 3'b111 : 3'b001);
    none_free = ~|avail;
    pick = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) if (avail[b]) pick = 2'(b);
    byte_live   = frm_byte_vld_i & active_q & ~drop_q & ~frm_start_i;
    byte_take   = byte_live & ((cnt_q != '0) | match) & (cnt_q < LEN_W'(MAX_LEN));
    byte_reject = byte_live & (cnt_q == '0) & ~match;
    cnt_eff     = cnt_q + LEN_W'(byte_take);
    commit      = frm_end_i & ~frm_start_i & active_q & ~drop_q & ~byte_reject &
                  (cnt_eff != '0) & ~ctrl_q[tgt_q];
    irq_set     = commit ? (3'b001 << tgt_q) : 3'b000;
  end

  // frame capture sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      drop_q   <= 1'b0;
      tgt_q    <= '0;
      cnt_q    <= '0;
    end else if (frm_start_i) begin
      active_q <= 1'b1;
      drop_q   <= none_free;
      tgt_q    <= pick;
      cnt_q    <= '0;
    end else begin
      if (byte_take)   cnt_q  <= cnt_q + 1'b1;
      if (byte_reject) drop_q <= 1'b1;
      if (frm_end_i)   active_q <= 1'b0;
    end
  end

  generate
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      always_ff @(posedge clk_i) begin
        if (byte_take && tgt_q == 2'(b)) mem_q[b][cnt_q[IDX_W-1:0]] <= frm_byte_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) len_q[b] <= '0;
        else if (commit && tgt_q == 2'(b)) len_q[b] <= cnt_eff;
      end
    end
  endgenerate

  // software registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 4'h8;
      la01_q <= '0;
      la2_q  <= '0;
      laen_q <= '0;
      irq_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == A_CTRL) ctrl_q <= reg_wdata_i[3:0];
      if (reg_wr_i && reg_addr_i == A_LA01) la01_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == A_LA2)  la2_q  <= reg_wdata_i[3:0];
      if (reg_wr_i && reg_addr_i == A_LAEN) laen_q <= reg_wdata_i[6:4];
      if (reg_wr_i && reg_addr_i == A_IRQ) begin
        irq_q <= (irq_q & ~reg_wdata_i[2:0]) | irq_set;
        ovf_q <= (ovf_q & ~reg_wdata_i[3]) | (frm_start_i & none_free);
      end else begin
        irq_q <= irq_q | irq_set;
        ovf_q <= ovf_q | (frm_start_i & none_free);
      end
    end
  end

  always_comb begin
    logic [1:0] sel;
    sel = reg_addr_i[ADDR_W-1:IDX_W] - 2'd1;
    reg_rdata_o = '0;
    if (reg_addr_i[ADDR_W-1:IDX_W] != '0) begin
      reg_rdata_o = mem_q[sel][reg_addr_i[IDX_W-1:0]];
    end else begin
      case (reg_addr_i)
        A_ORDER: reg_rdata_o = 8'(rank_pk);
        A_CTRL:  reg_rdata_o = {4'h0, ctrl_q};
        A_IRQ:   reg_rdata_o = {4'h0, ovf_q, irq_q};
        A_LA01:  reg_rdata_o = la01_q;
        A_LA2:   reg_rdata_o = {4'h0, la2_q};
        A_LAEN:  reg_rdata_o = {1'b0, laen_q, 4'h0};
        A_LEN0, A_LEN0 + 6'd1, A_LEN0 + 6'd2:
                 reg_rdata_o = 8'(len_q[reg_addr_i[1:0]]);
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign irq_ready_o = irq_q;
  assign overflow_o  = ovf_q;

  assert_irq_on_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> irq_ready_o[$past(tgt_q)]);

  assert_len_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q[0] <= LEN_W'(MAX_LEN)) && (len_q[1] <= LEN_W'(MAX_LEN)) &&
    (len_q[2] <= LEN_W'(MAX_LEN)));

  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !(reg_wr_i && reg_addr_i == A_IRQ && reg_wdata_i[3])) |=> overflow_o);

  assert_single_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !ctrl_q[3]) |-> (tgt_q == 2'd0));
endmodule

// File: tb/rx_frame_store_tb.sv
module rx_frame_store_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 1'b0, frm_vld = 1'b0, frm_end = 1'b0, reg_wr = 1'b0;
  logic [7:0] frm_byte = '0, reg_wdata = '0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_rdata;
  logic [2:0] irq_ready;
  logic overflow;

  int checks = 0;
  int errors = 0;
  logic [7:0] fb [0:19];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_store dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .frm_start_i(frm_start), .frm_byte_vld_i(frm_vld), .frm_byte_i(frm_byte), .frm_end_i(frm_end),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_ready_o(irq_ready), .overflow_o(overflow)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input int n);
    @(negedge clk);
    frm_start = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frm_start = 1'b0; frm_vld = 1'b1; frm_byte = fb[i];
    end
    @(negedge clk);
    frm_start = 1'b0; frm_vld = 1'b0; frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 order", 6'h00, 8'h00);
    rd_chk("R1 ctrl", 6'h01, 8'h08);
    rd_chk("R1 irq", 6'h02, 8'h00);
    chk("R1 irq pins", {5'b0, irq_ready}, 8'h00);
    chk("R1 overflow pin", {7'b0, overflow}, 8'h00);
  endtask

  task automatic t_setup_addrs();
    wr(6'h03, 8'h54);
    wr(6'h04, 8'h06);
    wr(6'h05, 8'h70);
  endtask

  task automatic t_store_first();
    fb[0] = 8'h14; fb[1] = 8'h11; fb[2] = 8'h22;
    send(3);
    chk("R8 irq pin buf0", {5'b0, irq_ready}, 8'h01);
    rd_chk("R2 len buf0", 6'h08, 8'h03);
    rd_chk("R2 byte0 buf0", 6'h10, 8'h14);
    rd_chk("R2 byte2 buf0", 6'h12, 8'h22);
    rd_chk("R3 order one", 6'h00, 8'h01);
  endtask

  task automatic t_broadcast_second();
    fb[0] = 8'h1F; fb[1] = 8'hAA;
    send(2);
    rd_chk("R6 broadcast len buf1", 6'h09, 8'h02);
    rd_chk("R2 byte1 buf1", 6'h21, 8'hAA);
    rd_chk("R3 order two", 6'h00, 8'h09);
  endtask

  task automatic t_long_third();
    for (int i = 0; i < 18; i++) fb[i] = (i == 0) ? 8'h26 : 8'(8'h40 + i);
    send(18);
    rd_chk("R5 len capped", 6'h0A, 8'h10);
    rd_chk("R5 last kept byte", 6'h3F, 8'h4F);
    rd_chk("R3 order three", 6'h00, 8'h39);
    rd_chk("R8 irq all", 6'h02, 8'h07);
  endtask

  task automatic t_overflow();
    fb[0] = 8'h14; fb[1] = 8'h99;
    send(2);
    rd_chk("R7 order unchanged", 6'h00, 8'h39);
    rd_chk("R7 buf0 byte kept", 6'h11, 8'h11);
    rd_chk("R7 buf0 len kept", 6'h08, 8'h03);
    rd_chk("R7 flag set", 6'h02, 8'h0F);
    chk("R7 overflow pin", {7'b0, overflow}, 8'h01);
    wr(6'h02, 8'h00);
    chk("R7 sticky", {7'b0, overflow}, 8'h01);
    wr(6'h02, 8'h08);
    chk("R7 w1c", {7'b0, overflow}, 8'h00);
  endtask

  task automatic t_release_rerank();
    wr(6'h01, 8'h09);
    wr(6'h01, 8'h08);
    rd_chk("R4 rerank after free", 6'h00, 8'h24);
    fb[0] = 8'h35; fb[1] = 8'h01;
    send(2);
    rd_chk("R4 reuse freed buf0", 6'h00, 8'h27);
    rd_chk("R4 new data buf0", 6'h11, 8'h01);
  endtask

  task automatic t_filter();
    wr(6'h01, 8'h0A);
    wr(6'h01, 8'h08);
    rd_chk("R4 rerank middle", 6'h00, 8'h12);
    wr(6'h02, 8'h07);
    fb[0] = 8'h17; fb[1] = 8'h55;
    send(2);
    rd_chk("R6 unmatched order", 6'h00, 8'h12);
    chk("R6 unmatched irq", {5'b0, irq_ready}, 8'h00);
    wr(6'h05, 8'h60);
    fb[0] = 8'h14;
    send(1);
    rd_chk("R6 disabled slot", 6'h00, 8'h12);
    fb[0] = 8'h25; fb[1] = 8'h66;
    send(2);
    rd_chk("R6 slot1 match", 6'h00, 8'h1E);
    chk("R8 irq buf1", {5'b0, irq_ready}, 8'h02);
  endtask

  task automatic t_irq_w1c();
    wr(6'h02, 8'h01);
    chk("R8 w1c other bit", {5'b0, irq_ready}, 8'h02);
    wr(6'h02, 8'h02);
    chk("R8 w1c clears", {5'b0, irq_ready}, 8'h00);
  endtask

  task automatic t_empty_frame();
    wr(6'h01, 8'h0F);
    wr(6'h01, 8'h08);
    rd_chk("R9 flush all", 6'h00, 8'h00);
    send(0);
    rd_chk("R10 empty order", 6'h00, 8'h00);
    chk("R10 empty irq", {5'b0, irq_ready}, 8'h00);
  endtask

  task automatic t_single_mode();
    wr(6'h01, 8'h00);
    fb[0] = 8'h3F;
    send(1);
    rd_chk("R9 single buf0", 6'h00, 8'h01);
    send(1);
    rd_chk("R9 single order kept", 6'h00, 8'h01);
    chk("R9 second lost", {7'b0, overflow}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setup_addrs();
    t_store_first();
    t_broadcast_second();
    t_long_third();
    t_overflow();
    t_release_rerank();
    t_filter();
    t_irq_w1c();
    t_empty_frame();
    t_single_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule